// File: doc/BRIEF.md
# Programmable Three-Port Parallel Interface with Handshake

This block gives a processor three 8-bit parallel ports, named A, B and C, on a small register bus. The bus has a 2-bit address, 8-bit write and read data, and single-cycle write and read strobes. Ports A and B carry data. Port C either serves as a general 8-bit port or supplies the handshake and status lines for A and B.

A control write sets up two groups. Group A is port A plus the upper half of port C, and it runs in one of three modes:
- basic I/O;
- strobed I/O with a handshake;
- a bidirectional bus.

Group B is port B plus the lower half of port C, and it runs as basic or strobed I/O.

In the strobed and bidirectional modes, selected port C bits take on fixed roles: strobe, input-buffer-full, output-buffer-full (active low), acknowledge and interrupt request. The interrupt-enable flags are the port C latch bits at the strobe and acknowledge positions. A control write with the top bit clear sets or clears one port C latch bit.

Pads are not modelled. Every port has separate input, output and per-bit output-enable vectors. The strobe and acknowledge inputs pass through a parameterised synchroniser before their edges are detected.

Top module: `ppi_port`

## Requirements
- R1: After reset no port drives: pa_oe, pb_oe and pc_oe are zero, the output latches are zero, and the control word selects basic mode with every port as an input.
- R2: A write of an address-3 word with bit 7 set is a mode-set word. Its fields are:
  - bits 6:5 select the group A mode: 00 basic, 01 strobed, 1X bidirectional;
  - bit 4: port A is an input;
  - bit 3: port C upper half is an input;
  - bit 2: group B is in strobed mode;
  - bit 1: port B is an input;
  - bit 0: port C lower half is an input.

  Every mode-set word clears the A, B and C output latches and all handshake flags.
- R3: In basic mode, an output port drives its latch with all enables set. An input port has all enables clear, and a read returns its pins. A read of an output port returns its latch.
- R4: An address-3 write with bit 7 clear writes bit 0 into the port C latch bit that bits 3:1 select. For example, 0x0D sets bit 6 and 0x0E clears bit 7.
- R5: With port A in strobed input mode (word 0xB0), a fall on PC4 latches pa_in and sets input-buffer-full on PC5. A later rise on PC4 raises the interrupt request on PC3 if interrupt enable (latch bit 4) is set. A read of port A returns the latched byte and clears PC5 and PC3. Port A does not drive in this mode.
- R6: With port A in strobed output mode, a port A write drives PC7 low (buffer full) and clears the interrupt request. A fall on PC6 (acknowledge) returns PC7 high. The following rise on PC6 raises PC3 if interrupt enable (latch bit 6) is set.
- R7: In bidirectional mode (word 0xC0), port A drives its latch only while PC6 is low. PC7 reports output-buffer-full, active low. The input side follows R5 using PC4 and PC5.
- R8: With group B strobed, PC2 is the strobe (input) or the acknowledge (output), PC1 is input-buffer-full or output-buffer-full (active low), and PC0 is the interrupt request. Interrupt enable is latch bit 2.
- R9: A read of port C returns the handshake status on handshake output bits and the enable flags at the strobe and acknowledge positions. General bits return the latch for outputs and the pins for inputs.
- R10: The interrupt request stays low after a complete strobe or acknowledge pulse while the matching interrupt enable is clear.
- R11: Read data is registered: rdata and a one-cycle rd_valid appear in the cycle after rd_en. A read of address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select: 0 port A, 1 port B, 2 port C, 3 control |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| rdata | output | 8 | Registered read data |
| rd_valid | output | 1 | High for one cycle when rdata holds a result |
| pa_in | input | 8 | Port A pin input |
| pa_out | output | 8 | Port A output value |
| pa_oe | output | 8 | Port A per-bit output enable |
| pb_in | input | 8 | Port B pin input |
| pb_out | output | 8 | Port B output value |
| pb_oe | output | 8 | Port B per-bit output enable |
| pc_in | input | 8 | Port C pin input, including the strobe and acknowledge lines |
| pc_out | output | 8 | Port C output value, including the handshake status lines |
| pc_oe | output | 8 | Port C per-bit output enable |

## Verification
The assertions check the following on every cycle:
- a mode-set word clears the latches;
- a single-bit command lands in the bit it selects;
- a port A write in strobed output mode drops the buffer-full line;
- a port A read in strobed input mode clears input-buffer-full and the interrupt;
- port A stays undriven in strobed input mode;
- the interrupt request never rises while its enable is clear.

Only the bench scenarios can show the rest:
- the latched data is the byte present at the strobe's falling edge, not the byte present later;
- the acknowledge sequence, where the buffer-full line is released on the falling edge and the interrupt is raised on the rising edge;
- bidirectional output enabled only while acknowledge is low;
- the per-mode composition of the port C read word.

// File: rtl/ppi_pkg.sv
package ppi_pkg;

   // Group A operating mode after decode of the two-bit field
   typedef enum logic [1:0] {
      GM_BASIC    = 2'd0,
      GM_STROBED  = 2'd1,
      GM_BIDIR    = 2'd2
   } grp_mode_e;

   // Stored mode-set word, bit 7 dropped (bit order is what software writes)
   typedef struct packed {
      logic [1:0] a_mode;
      logic       a_in;
      logic       cu_in;
      logic       b_mode;
      logic       b_in;
      logic       cl_in;
   } ctl_word_t;

   localparam int              CTL_W     = 7;
   localparam logic [CTL_W-1:0] CTL_RESET = 7'h1B;

   localparam logic [1:0] ADR_A   = 2'd0;
   localparam logic [1:0] ADR_B   = 2'd1;
   localparam logic [1:0] ADR_C   = 2'd2;
   localparam logic [1:0] ADR_CTL = 2'd3;

   // Port C bit roles used by the handshake modes
   localparam int PC_OBF_A  = 7;
   localparam int PC_ACK_A  = 6;
   localparam int PC_IBF_A  = 5;
   localparam int PC_STB_A  = 4;
   localparam int PC_INTR_A = 3;
   localparam int PC_HS_B   = 2;
   localparam int PC_BUF_B  = 1;
   localparam int PC_INTR_B = 0;

endpackage

// File: rtl/ppi_sync.sv
module ppi_sync #(
   parameter int            W       = 3,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 1 || STAGES > 4) begin : g_bad_stages
      $error("ppi_sync: STAGES must lie in 1..4");
   end

   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];

endmodule

// File: rtl/ppi_hs_chan.sv
module ppi_hs_chan #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          in_en,
   input  logic          out_en,
   input  logic          inte_in,
   input  logic          inte_out,
   input  logic          stb_n,
   input  logic          ack_n,
   input  logic [DW-1:0] pin_d,
   input  logic          cpu_rd,
   input  logic          cpu_wr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] in_q,
   output logic [DW-1:0] out_q,
   output logic          ibf,
   output logic          obf,
   output logic          intr
);

   logic stb_q, ack_q;
   logic intr_i, intr_o;
   logic stb_fall, stb_rise, ack_fall, ack_rise;

   assign stb_fall = stb_q & ~stb_n;
   assign stb_rise = ~stb_q & stb_n;
   assign ack_fall = ack_q & ~ack_n;
   assign ack_rise = ~ack_q & ack_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stb_q  <= 1'b1;
         ack_q  <= 1'b1;
         in_q   <= '0;
         out_q  <= '0;
         ibf    <= 1'b0;
         obf    <= 1'b0;
         intr_i <= 1'b0;
         intr_o <= 1'b0;
      end else begin
         stb_q <= stb_n;
         ack_q <= ack_n;
         if (clr) begin
            in_q   <= '0;
            out_q  <= '0;
            ibf    <= 1'b0;
            obf    <= 1'b0;
            intr_i <= 1'b0;
            intr_o <= 1'b0;
         end else begin
            // input half: capture on strobe fall, interrupt on strobe rise
            if (in_en) begin
               if (stb_fall) begin
                  in_q <= pin_d;
                  ibf  <= 1'b1;
               end
               if (stb_rise && ibf && inte_in) intr_i <= 1'b1;
               if (cpu_rd) begin
                  ibf    <= 1'b0;
                  intr_i <= 1'b0;
               end
            end
            if (cpu_wr) out_q <= wdata;
            // output half: full on write, empty on ack fall, interrupt on ack rise
            if (out_en) begin
               if (ack_fall) obf <= 1'b0;
               if (ack_rise && !obf && inte_out) intr_o <= 1'b1;
               if (cpu_wr) begin
                  obf    <= 1'b1;
                  intr_o <= 1'b0;
               end
            end
         end
      end
   end

   assign intr = intr_i | intr_o;

endmodule

// File: rtl/ppi_port.sv
module ppi_port
   import ppi_pkg::*;
#(
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_BIDIR   = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    addr,
   input  logic [DW-1:0] wdata,
   input  logic          wr_en,
   input  logic          rd_en,
   output logic [DW-1:0] rdata,
   output logic          rd_valid,
   input  logic [DW-1:0] pa_in,
   output logic [DW-1:0] pa_out,
   output logic [DW-1:0] pa_oe,
   input  logic [DW-1:0] pb_in,
   output logic [DW-1:0] pb_out,
   output logic [DW-1:0] pb_oe,
   input  logic [DW-1:0] pc_in,
   output logic [DW-1:0] pc_out,
   output logic [DW-1:0] pc_oe
);

   localparam int NCH  = 2;
   localparam int HALF = DW / 2;
   localparam int IW   = $clog2(DW);
   localparam int NHS  = 3;

   if (DW != 8) begin : g_bad_dw
      $error("ppi_port: control word layout needs DW == 8");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("ppi_port: SYNC_STAGES must be at least 1");
   end

   // ---------------- control word and port C latch ----------------
   ctl_word_t     cw;
   logic [DW-1:0] pc_lat;
   logic          wr_ctl, mode_set, bit_op;

   assign wr_ctl   = wr_en && (addr == ADR_CTL);
   assign mode_set = wr_ctl && wdata[DW-1];
   assign bit_op   = wr_ctl && !wdata[DW-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cw     <= ctl_word_t'(CTL_RESET);
         pc_lat <= '0;
      end else if (mode_set) begin
         cw     <= ctl_word_t'(wdata[CTL_W-1:0]);
         pc_lat <= '0;
      end else if (bit_op) begin
         pc_lat[wdata[IW:1]] <= wdata[0];
      end else if (wr_en && addr == ADR_C) begin
         pc_lat <= wdata;
      end
   end

   // ---------------- mode decode ----------------
   grp_mode_e a_mode;
   if (HAS_BIDIR) begin : g_bidir
      assign a_mode = (cw.a_mode == 2'b00) ? GM_BASIC :
                      (cw.a_mode == 2'b01) ? GM_STROBED : GM_BIDIR;
   end else begin : g_no_bidir
      assign a_mode = (cw.a_mode == 2'b00) ? GM_BASIC : GM_STROBED;
   end

   logic a_m1_in, a_m1_out, a_bidir, b_m1;
   assign a_m1_in  = (a_mode == GM_STROBED) && cw.a_in;
   assign a_m1_out = (a_mode == GM_STROBED) && !cw.a_in;
   assign a_bidir  = (a_mode == GM_BIDIR);
   assign b_m1     = cw.b_mode;

   // ---------------- handshake input synchroniser ----------------
   logic [NHS-1:0] hs_s;
   ppi_sync #(.W(NHS), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({pc_in[PC_ACK_A], pc_in[PC_STB_A], pc_in[PC_HS_B]}),
      .q     (hs_s)
   );

   // ---------------- handshake channels (0 = port A, 1 = port B) ----------------
   logic [NCH-1:0] ch_in_en, ch_out_en, ch_inte_in, ch_inte_out;
   logic [NCH-1:0] ch_stb, ch_ack, ch_rd, ch_wr;
   logic [NCH-1:0] ch_ibf, ch_obf, ch_intr;
   logic [DW-1:0]  ch_pin   [NCH];
   logic [DW-1:0]  ch_in_q  [NCH];
   logic [DW-1:0]  ch_out_q [NCH];

   assign ch_in_en[0]    = a_m1_in || a_bidir;
   assign ch_out_en[0]   = a_m1_out || a_bidir;
   assign ch_inte_in[0]  = pc_lat[PC_STB_A];
   assign ch_inte_out[0] = pc_lat[PC_ACK_A];
   assign ch_stb[0]      = hs_s[1];
   assign ch_ack[0]      = hs_s[2];
   assign ch_rd[0]       = rd_en && (addr == ADR_A);
   assign ch_wr[0]       = wr_en && (addr == ADR_A);
   assign ch_pin[0]      = pa_in;

   assign ch_in_en[1]    = b_m1 && cw.b_in;
   assign ch_out_en[1]   = b_m1 && !cw.b_in;
   assign ch_inte_in[1]  = pc_lat[PC_HS_B];
   assign ch_inte_out[1] = pc_lat[PC_HS_B];
   assign ch_stb[1]      = hs_s[0];
   assign ch_ack[1]      = hs_s[0];
   assign ch_rd[1]       = rd_en && (addr == ADR_B);
   assign ch_wr[1]       = wr_en && (addr == ADR_B);
   assign ch_pin[1]      = pb_in;

   for (genvar g = 0; g < NCH; g++) begin : g_chan
      ppi_hs_chan #(.DW(DW)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr      (mode_set),
         .in_en    (ch_in_en[g]),
         .out_en   (ch_out_en[g]),
         .inte_in  (ch_inte_in[g]),
         .inte_out (ch_inte_out[g]),
         .stb_n    (ch_stb[g]),
         .ack_n    (ch_ack[g]),
         .pin_d    (ch_pin[g]),
         .cpu_rd   (ch_rd[g]),
         .cpu_wr   (ch_wr[g]),
         .wdata    (wdata),
         .in_q     (ch_in_q[g]),
         .out_q    (ch_out_q[g]),
         .ibf      (ch_ibf[g]),
         .obf      (ch_obf[g]),
         .intr     (ch_intr[g])
      );
   end

   // ---------------- port A / B pins ----------------
   assign pa_out = ch_out_q[0];
   assign pb_out = ch_out_q[1];

   always_comb begin
      unique case (a_mode)
         GM_BIDIR: pa_oe = hs_s[2] ? '0 : '1;
         default:  pa_oe = cw.a_in ? '0 : '1;
      endcase
   end
   assign pb_oe = cw.b_in ? '0 : '1;

   // ---------------- port C roles ----------------
   logic [DW-1:0] hs_in_mask;

   always_comb begin
      pc_oe      = {{HALF{~cw.cu_in}}, {HALF{~cw.cl_in}}};
      pc_out     = pc_lat;
      hs_in_mask = '0;
      if (a_m1_in || a_bidir) begin
         pc_oe[PC_IBF_A]      = 1'b1;
         pc_out[PC_IBF_A]     = ch_ibf[0];
         pc_oe[PC_STB_A]      = 1'b0;
         hs_in_mask[PC_STB_A] = 1'b1;
      end
      if (a_m1_out || a_bidir) begin
         pc_oe[PC_OBF_A]      = 1'b1;
         pc_out[PC_OBF_A]     = ~ch_obf[0];
         pc_oe[PC_ACK_A]      = 1'b0;
         hs_in_mask[PC_ACK_A] = 1'b1;
      end
      if (a_mode != GM_BASIC) begin
         pc_oe[PC_INTR_A]  = 1'b1;
         pc_out[PC_INTR_A] = ch_intr[0];
      end
      if (b_m1) begin
         pc_oe[PC_HS_B]      = 1'b0;
         hs_in_mask[PC_HS_B] = 1'b1;
         pc_oe[PC_BUF_B]     = 1'b1;
         pc_out[PC_BUF_B]    = cw.b_in ? ch_ibf[1] : ~ch_obf[1];
         pc_oe[PC_INTR_B]    = 1'b1;
         pc_out[PC_INTR_B]   = ch_intr[1];
      end
   end

   // ---------------- read path ----------------
   logic [DW-1:0] rd_mux;

   always_comb begin
      unique case (addr)
         ADR_A: begin
            if (a_mode == GM_BASIC) rd_mux = cw.a_in ? pa_in : ch_out_q[0];
            else                    rd_mux = a_m1_out ? ch_out_q[0] : ch_in_q[0];
         end
         ADR_B: begin
            if (!b_m1) rd_mux = cw.b_in ? pb_in : ch_out_q[1];
            else       rd_mux = cw.b_in ? ch_in_q[1] : ch_out_q[1];
         end
         ADR_C:   rd_mux = (pc_oe & pc_out) | (hs_in_mask & pc_lat) |
                           (~pc_oe & ~hs_in_mask & pc_in);
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata    <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rdata <= rd_mux;
      end
   end

endmodule

// File: rtl/ppi_port_chk.sv
module ppi_port_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic [1:0]    addr,
   input logic [DW-1:0] wdata,
   input logic          wr_en,
   input logic          rd_en,
   input logic [DW-1:0] pa_out,
   input logic [DW-1:0] pb_out,
   input logic [DW-1:0] pa_oe,
   input logic [DW-1:0] pc_out,
   input logic [DW-1:0] pc_lat,
   input logic          a_m1_in,
   input logic          a_m1_out
);

   localparam int IW = $clog2(DW);

   // R2
   mode_set_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd3 && wdata[DW-1]) |=>
         (pa_out == '0 && pb_out == '0 && pc_lat == '0));

   // R4
   bit_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd3 && !wdata[DW-1]) |=>
         (pc_lat[$past(wdata[IW:1])] == $past(wdata[0])));

   // R6
   obf_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_m1_out && wr_en && addr == 2'd0) |=> !pc_out[7]);

   // R5
   ibf_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_m1_in && rd_en && addr == 2'd0) |=> (!pc_out[5] && !pc_out[3]));

   // R5
   strobed_in_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      a_m1_in |-> (pa_oe == '0));

   // R10
   intr_needs_inte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_m1_in && $past(a_m1_in) && $rose(pc_out[3])) |-> $past(pc_lat[4]));

endmodule

bind ppi_port ppi_port_chk #(.DW(DW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .addr     (addr),
   .wdata    (wdata),
   .wr_en    (wr_en),
   .rd_en    (rd_en),
   .pa_out   (pa_out),
   .pb_out   (pb_out),
   .pa_oe    (pa_oe),
   .pc_out   (pc_out),
   .pc_lat   (pc_lat),
   .a_m1_in  (a_m1_in),
   .a_m1_out (a_m1_out)
);

// File: tb/ppi_port_tb.sv
module ppi_port_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] addr = '0;
   logic [7:0] wdata = '0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] rdata;
   logic       rd_valid;
   logic [7:0] pa_in = '0, pb_in = '0, pc_in = 8'hFF;
   logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  done     = 1'b0;

   logic [7:0] exp_q [$];
   string      tag_q [$];
   logic [7:0] mon_exp;
   string      mon_tag;

   always #5 clk = ~clk;

   ppi_port u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
      .rd_en(rd_en), .rdata(rdata), .rd_valid(rd_valid),
      .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
      .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
      .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
   );

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // driver: issues the read and queues what the monitor must see
   task automatic bus_rd(input logic [1:0] a, input logic [7:0] e, input string tag);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   // monitor: compares registered read data against the queue
   always @(negedge clk) begin
      if (rd_valid) begin
         n_checks++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R11: actual unexpected read %h expected none", rdata);
         end else begin
            mon_exp = exp_q.pop_front();
            mon_tag = tag_q.pop_front();
            if (rdata !== mon_exp) begin
               n_fail++;
               $display("FAIL %s: actual %h expected %h", mon_tag, rdata, mon_exp);
            end
         end
      end
   end

   initial begin
      repeat (30000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      check(pa_oe, 8'h00, "R1 pa_oe");
      check(pb_oe, 8'h00, "R1 pb_oe");
      check(pc_oe, 8'h00, "R1 pc_oe");
      check(pa_out, 8'h00, "R1 pa_out");
      check({7'd0, rd_valid}, 8'h00, "R11 rd_valid idle");

      // R3/R9 basic inputs read pins
      pa_in = 8'h5A;
      bus_rd(2'd0, 8'h5A, "R3 port A pins");
      pc_in = 8'hF5;
      bus_rd(2'd2, 8'hF5, "R9 port C pins");
      pc_in = 8'hFF;

      // R3 basic outputs
      bus_wr(2'd3, 8'h80);
      bus_wr(2'd0, 8'h3C);
      check(pa_out, 8'h3C, "R3 pa_out");
      check(pa_oe, 8'hFF, "R3 pa_oe");
      bus_wr(2'd1, 8'hA5);
      check(pb_oe, 8'hFF, "R3 pb_oe");
      bus_rd(2'd1, 8'hA5, "R3 port B latch read");
      bus_wr(2'd2, 8'h81);
      check(pc_out, 8'h81, "R9 pc_out");
      check(pc_oe, 8'hFF, "R9 pc_oe");
      bus_rd(2'd2, 8'h81, "R9 port C latch read");

      // R4 single-bit commands
      bus_wr(2'd3, 8'h0D);
      bus_wr(2'd3, 8'h0E);
      check(pc_out, 8'h41, "R4 set bit6 clear bit7");
      bus_rd(2'd2, 8'h41, "R4 port C read");

      // R2 mode-set clears latches, R11 address 3 reads zero
      bus_wr(2'd3, 8'h80);
      check(pa_out, 8'h00, "R2 pa_out cleared");
      check(pb_out, 8'h00, "R2 pb_out cleared");
      check(pc_out, 8'h00, "R2 pc_out cleared");
      bus_rd(2'd3, 8'h00, "R11 control read");

      // R5 strobed input on port A
      bus_wr(2'd3, 8'hB0);
      check(pa_oe, 8'h00, "R5 port A not driven");
      bus_rd(2'd2, 8'h00, "R9 status after 0xB0");
      bus_wr(2'd3, 8'h09);
      pa_in = 8'h77;
      pc_in[4] = 1'b0;
      idle(5);
      check({7'd0, pc_out[5]}, 8'h01, "R5 IBF after strobe fall");
      check({7'd0, pc_out[3]}, 8'h00, "R5 INTR low while strobe low");
      pa_in = 8'h11;
      pc_in[4] = 1'b1;
      idle(5);
      check({7'd0, pc_out[3]}, 8'h01, "R5 INTR after strobe rise");
      bus_rd(2'd2, 8'h38, "R9 status IBF INTE INTR");
      bus_rd(2'd0, 8'h77, "R5 latched byte");
      check({6'd0, pc_out[5], pc_out[3]}, 8'h00, "R5 flags cleared by read");

      // R10 no interrupt with enable clear
      bus_wr(2'd3, 8'h08);
      pa_in = 8'h22;
      pc_in[4] = 1'b0;
      idle(5);
      pc_in[4] = 1'b1;
      idle(5);
      check({6'd0, pc_out[5], pc_out[3]}, 8'h02, "R10 IBF set INTR low");
      bus_rd(2'd0, 8'h22, "R5 second byte");

      // R6 strobed output on port A
      bus_wr(2'd3, 8'hA0);
      check({7'd0, pc_out[7]}, 8'h01, "R6 OBF idle high");
      check(pa_oe, 8'hFF, "R6 pa_oe");
      bus_wr(2'd3, 8'h0D);
      bus_wr(2'd0, 8'h99);
      check(pa_out, 8'h99, "R6 pa_out");
      check({7'd0, pc_out[7]}, 8'h00, "R6 OBF low after write");
      pc_in[6] = 1'b0;
      idle(5);
      check({7'd0, pc_out[7]}, 8'h01, "R6 OBF high after ack");
      pc_in[6] = 1'b1;
      idle(5);
      check({7'd0, pc_out[3]}, 8'h01, "R6 INTR after ack rise");
      bus_wr(2'd0, 8'h42);
      check({6'd0, pc_out[7], pc_out[3]}, 8'h00, "R6 write clears INTR");
      bus_rd(2'd2, 8'h40, "R9 status output mode");

      // R7 bidirectional port A
      bus_wr(2'd3, 8'hC0);
      bus_rd(2'd2, 8'h80, "R9 status bidir idle");
      check(pa_oe, 8'h00, "R7 no drive with ack high");
      bus_wr(2'd0, 8'h5E);
      check(pa_oe, 8'h00, "R7 still no drive after write");
      check({7'd0, pc_out[7]}, 8'h00, "R7 OBF low");
      pc_in[6] = 1'b0;
      idle(5);
      check(pa_oe, 8'hFF, "R7 drive while ack low");
      check(pa_out, 8'h5E, "R7 driven byte");
      check({7'd0, pc_out[7]}, 8'h01, "R7 OBF released");
      pc_in[6] = 1'b1;
      idle(5);
      check(pa_oe, 8'h00, "R7 release after ack");
      check({7'd0, pc_out[3]}, 8'h00, "R10 bidir INTR with enables clear");
      pa_in = 8'h6B;
      pc_in[4] = 1'b0;
      idle(5);
      pc_in[4] = 1'b1;
      idle(5);
      check({7'd0, pc_out[5]}, 8'h01, "R7 IBF set");
      bus_rd(2'd0, 8'h6B, "R7 input byte");
      check({7'd0, pc_out[5]}, 8'h00, "R7 IBF cleared");

      // R8 group B strobed input
      bus_wr(2'd3, 8'h86);
      check(pb_oe, 8'h00, "R8 port B not driven");
      bus_wr(2'd3, 8'h05);
      pb_in = 8'hC3;
      pc_in[2] = 1'b0;
      idle(5);
      check({7'd0, pc_out[1]}, 8'h01, "R8 IBF B");
      pc_in[2] = 1'b1;
      idle(5);
      check({7'd0, pc_out[0]}, 8'h01, "R8 INTR B");
      bus_rd(2'd1, 8'hC3, "R8 latched byte B");
      check({6'd0, pc_out[1:0]}, 8'h00, "R8 flags cleared");

      // R8 group B strobed output
      bus_wr(2'd3, 8'h84);
      bus_rd(2'd2, 8'h02, "R9 status B output idle");
      bus_wr(2'd3, 8'h05);
      bus_wr(2'd1, 8'h1F);
      check(pb_out, 8'h1F, "R8 pb_out");
      check({7'd0, pc_out[1]}, 8'h00, "R8 OBF B low");
      pc_in[2] = 1'b0;
      idle(5);
      check({7'd0, pc_out[1]}, 8'h01, "R8 OBF B released");
      pc_in[2] = 1'b1;
      idle(5);
      check({7'd0, pc_out[0]}, 8'h01, "R8 INTR B after ack");

      idle(3);
      check(8'(exp_q.size()), 8'h00, "R11 all reads returned");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule